// File: doc/BRIEF.md
# Sensor Debug Session Sequencer

This block runs a fixed bring-up session against a pressure sensor over a separate byte-transaction engine. The engine handles the serial framing. This block issues one request at a time and waits for the engine to answer. When it sees `start`, it does the following in order:

1. It sends one dummy transaction to flush the fault that the sensor latches at power-up.
2. It writes the hold code to the sensor's operations-control register.
3. It reads that register back to confirm that the sensor core is halted.
4. It reads two identification bytes from the memory window that the range field selects.
5. It writes zero to the control register, which lets the core run again.

If the readback does not match, the block inserts a dummy and repeats the write and the readback. A bounded retry counter stops this loop. An engine abort ends the session at once. Both of these failures set the error flag. The two captured bytes stay on the outputs after the session ends.

The control register is at address 0x038. Bit 2 halts the core and bits 1:0 select the window. With range 0 the identification bytes are the firmware pair at 0x805 (derivative) and 0x804 (version). With range 3 they are the hardware pair at 0x1542 (derivative) and 0x1543 (version). The hold code is therefore 0x04 or 0x07.

Top module: `sdbg_seq`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first `start`, `req_valid`, `req_write`, `req_dummy`, `req_addr`, `req_wdata`, `id_deriv`, `id_ver`, `done` and `error` are all 0.
- R2: A session issues requests in this order:
  - a dummy (`req_dummy`=1, `req_write`=0);
  - a write of `0x04|RANGE_SEL` to address 0x038;
  - a read of 0x038;
  - a read of the derivative address;
  - a read of the version address;
  - a write of 0x00 to 0x038.

  Every request field is 0 in any cycle in which `req_valid` is 0.
- R3: Each request is a `req_valid` pulse one cycle long. The next request is raised in the cycle right after the clock edge at which `eng_done` was sampled high while a request was outstanding. `eng_done` and `eng_abort` are ignored when no request is outstanding.
- R4: The readback of the control register matches when `eng_rdata[2:0]` equals the low three bits of the hold code. On a mismatch the sequencer starts again from the dummy, then repeats the write and the readback.
- R5: At most MAX_RETRY (default 8) mismatch retries are taken. The next mismatch ends the session with `done`=1 and `error`=1, and no release write is issued.
- R6: With RANGE_SEL=0 the derivative comes from 0x805 and the version from 0x804. With RANGE_SEL=3 they come from 0x1542 and 0x1543. The `eng_rdata` returned with each of these reads is stored in `id_deriv` and `id_ver` respectively.
- R7: If `eng_abort` is high while a request is outstanding, the session ends with `done`=1 and `error`=1, and no further request is issued. `eng_abort` takes priority over `eng_done`.
- R8: A successful session ends with `done`=1 and `error`=0. `done`, `error`, `id_deriv` and `id_ver` then stay unchanged until the next `start`. A `start` sampled during a session has no effect. A `start` sampled while idle or ended clears `done` and `error` and begins a new session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a session when idle or ended |
| req_valid | output | 1 | One-cycle request strobe to the engine |
| req_write | output | 1 | Request is a register write |
| req_dummy | output | 1 | Request is a dummy transaction |
| req_addr | output | ADDR_W | Register address of the request |
| req_wdata | output | 8 | Write data of the request |
| eng_done | input | 1 | Engine finished the outstanding request |
| eng_abort | input | 1 | Engine gave up on the outstanding request |
| eng_rdata | input | 8 | Read byte, valid with `eng_done` |
| id_deriv | output | 8 | Captured derivative byte |
| id_ver | output | 8 | Captured version byte |
| done | output | 1 | Session ended |
| error | output | 1 | Session ended by abort or by exhausted retries |

## Verification
The bench builds two copies of the block side by side. One uses RANGE_SEL=0 with an engine model that answers after three cycles. The other uses RANGE_SEL=3 with a one-cycle engine, so the readback compare against 0x07 and the hardware addresses are exercised alongside the firmware path. The engine model can ignore a set number of control writes and can abort the Nth request. With MAX_RETRY left at 8, this covers a recovered retry, an exhausted retry budget after nine readbacks, and an abort in the middle of a session. The first copy is compared on every clock against a behavioural model of the session.

// File: rtl/sdbg_pkg.sv
package sdbg_pkg;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_ISSUE,
      PH_WAIT,
      PH_END
   } phase_e;

   typedef enum logic [2:0] {
      ST_DUMMY,
      ST_HOLD_WR,
      ST_HOLD_RD,
      ST_DERIV_RD,
      ST_VER_RD,
      ST_RELEASE_WR
   } step_e;

   localparam int HOLD_BIT = 2;
   localparam int BYTE_W   = 8;

   localparam logic [15:0] CTRL_ADDR     = 16'h0038;
   localparam logic [15:0] FW_DERIV_ADDR = 16'h0805;
   localparam logic [15:0] FW_VER_ADDR   = 16'h0804;
   localparam logic [15:0] HW_DERIV_ADDR = 16'h1542;
   localparam logic [15:0] HW_VER_ADDR   = 16'h1543;

   function automatic logic [BYTE_W-1:0] hold_code(input int unsigned rng);
      logic [BYTE_W-1:0] v;
      v           = '0;
      v[HOLD_BIT] = 1'b1;
      v[1:0]      = 2'(rng);
      return v;
   endfunction

endpackage

// File: rtl/sdbg_retry.sv
module sdbg_retry #(
   parameter int MAX_RETRY = 8,
   localparam int CNT_W = $clog2(MAX_RETRY + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic             exhausted,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_RETRY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (clr)
         count <= '0;
      else if (inc && (count != LIMIT))
         count <= count + 1'b1;
   end

   assign exhausted = (count == LIMIT);

   p_retry_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      count <= LIMIT);

   p_no_inc_past_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      inc |-> !exhausted);

endmodule

// File: rtl/sdbg_fsm.sv
module sdbg_fsm
   import sdbg_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   eng_done,
   input  logic   eng_abort,
   input  logic   hold_match,
   input  logic   exhausted,
   output phase_e phase,
   output step_e  step,
   output logic   retry_clr,
   output logic   retry_inc,
   output logic   cap_deriv,
   output logic   cap_ver,
   output logic   done,
   output logic   error
);

   phase_e phase_n;
   step_e  step_n;
   logic   done_n, error_n;

   always_comb begin
      phase_n   = phase;
      step_n    = step;
      done_n    = done;
      error_n   = error;
      retry_clr = 1'b0;
      retry_inc = 1'b0;
      cap_deriv = 1'b0;
      cap_ver   = 1'b0;
      unique case (phase)
         PH_IDLE, PH_END: begin
            if (start) begin
               phase_n   = PH_ISSUE;
               step_n    = ST_DUMMY;
               done_n    = 1'b0;
               error_n   = 1'b0;
               retry_clr = 1'b1;
            end
         end
         PH_ISSUE: phase_n = PH_WAIT;
         PH_WAIT: begin
            if (eng_abort) begin
               phase_n = PH_END;
               done_n  = 1'b1;
               error_n = 1'b1;
            end else if (eng_done) begin
               phase_n = PH_ISSUE;
               unique case (step)
                  ST_DUMMY:   step_n = ST_HOLD_WR;
                  ST_HOLD_WR: step_n = ST_HOLD_RD;
                  ST_HOLD_RD: begin
                     if (hold_match) begin
                        step_n = ST_DERIV_RD;
                     end else if (exhausted) begin
                        phase_n = PH_END;
                        done_n  = 1'b1;
                        error_n = 1'b1;
                     end else begin
                        retry_inc = 1'b1;
                        step_n    = ST_DUMMY;
                     end
                  end
                  ST_DERIV_RD: begin
                     cap_deriv = 1'b1;
                     step_n    = ST_VER_RD;
                  end
                  ST_VER_RD: begin
                     cap_ver = 1'b1;
                     step_n  = ST_RELEASE_WR;
                  end
                  ST_RELEASE_WR: begin
                     phase_n = PH_END;
                     done_n  = 1'b1;
                  end
                  default: phase_n = PH_END;
               endcase
            end
         end
         default: phase_n = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         step  <= ST_DUMMY;
         done  <= 1'b0;
         error <= 1'b0;
      end else begin
         phase <= phase_n;
         step  <= step_n;
         done  <= done_n;
         error <= error_n;
      end
   end

   p_error_has_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> done);

   p_wait_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WAIT && !eng_done && !eng_abort) |=> (phase == PH_WAIT));

   p_release_follows_ver_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ISSUE && step == ST_RELEASE_WR) |-> ($past(step) == ST_VER_RD));

   p_abort_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WAIT && eng_abort) |=> (phase == PH_END && error));

endmodule

// File: rtl/sdbg_req_map.sv
module sdbg_req_map
   import sdbg_pkg::*;
#(
   parameter int ADDR_W    = 13,
   parameter int RANGE_SEL = 0
) (
   input  phase_e             phase,
   input  step_e              step,
   output logic               req_valid,
   output logic               req_write,
   output logic               req_dummy,
   output logic [ADDR_W-1:0]  req_addr,
   output logic [BYTE_W-1:0]  req_wdata
);

   localparam logic [BYTE_W-1:0] HOLD_VAL = hold_code(RANGE_SEL);

   logic [15:0] deriv_a, ver_a, addr16;

   generate
      if (RANGE_SEL == 3) begin : g_hw_win
         assign deriv_a = HW_DERIV_ADDR;
         assign ver_a   = HW_VER_ADDR;
      end else begin : g_fw_win
         assign deriv_a = FW_DERIV_ADDR;
         assign ver_a   = FW_VER_ADDR;
      end
   endgenerate

   always_comb begin
      req_valid = 1'b0;
      req_write = 1'b0;
      req_dummy = 1'b0;
      addr16    = '0;
      req_wdata = '0;
      if (phase == PH_ISSUE) begin
         req_valid = 1'b1;
         unique case (step)
            ST_DUMMY:   req_dummy = 1'b1;
            ST_HOLD_WR: begin
               req_write = 1'b1;
               addr16    = CTRL_ADDR;
               req_wdata = HOLD_VAL;
            end
            ST_HOLD_RD:    addr16 = CTRL_ADDR;
            ST_DERIV_RD:   addr16 = deriv_a;
            ST_VER_RD:     addr16 = ver_a;
            ST_RELEASE_WR: begin
               req_write = 1'b1;
               addr16    = CTRL_ADDR;
            end
            default: req_valid = 1'b0;
         endcase
      end
   end

   assign req_addr = addr16[ADDR_W-1:0];

endmodule

// File: rtl/sdbg_capture.sv
module sdbg_capture
   import sdbg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_deriv,
   input  logic              cap_ver,
   input  logic [BYTE_W-1:0] rdata,
   output logic [BYTE_W-1:0] id_deriv,
   output logic [BYTE_W-1:0] id_ver
);

   localparam int LANES = 2;

   logic [LANES-1:0] cap;
   assign cap = {cap_ver, cap_deriv};

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [BYTE_W-1:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lane_q <= '0;
         else if (cap[i])
            lane_q <= rdata;
      end
   end

   assign id_deriv = g_lane[0].lane_q;
   assign id_ver   = g_lane[1].lane_q;

   p_one_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cap));

endmodule

// File: rtl/sdbg_seq.sv
module sdbg_seq
   import sdbg_pkg::*;
#(
   parameter int ADDR_W    = 13,
   parameter int RANGE_SEL = 0,
   parameter int MAX_RETRY = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              req_valid,
   output logic              req_write,
   output logic              req_dummy,
   output logic [ADDR_W-1:0] req_addr,
   output logic [7:0]        req_wdata,
   input  logic              eng_done,
   input  logic              eng_abort,
   input  logic [7:0]        eng_rdata,
   output logic [7:0]        id_deriv,
   output logic [7:0]        id_ver,
   output logic              done,
   output logic              error
);

   localparam logic [BYTE_W-1:0] HOLD_VAL = hold_code(RANGE_SEL);
   localparam int CNT_W = $clog2(MAX_RETRY + 1);

   generate
      if (!(RANGE_SEL == 0 || RANGE_SEL == 3)) begin : g_bad_range
         $error("sdbg_seq: RANGE_SEL must select window 0 or 3");
      end
      if (ADDR_W < 13 || ADDR_W > 16) begin : g_bad_addr
         $error("sdbg_seq: ADDR_W must lie in 13..16");
      end
      if (MAX_RETRY < 1) begin : g_bad_retry
         $error("sdbg_seq: MAX_RETRY must be at least 1");
      end
   endgenerate

   phase_e            phase;
   step_e             step;
   logic              retry_clr, retry_inc, exhausted;
   logic              cap_deriv, cap_ver, hold_match;
   logic [CNT_W-1:0]  retry_count;

   assign hold_match = (eng_rdata[2:0] == HOLD_VAL[2:0]);

   sdbg_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .eng_done   (eng_done),
      .eng_abort  (eng_abort),
      .hold_match (hold_match),
      .exhausted  (exhausted),
      .phase      (phase),
      .step       (step),
      .retry_clr  (retry_clr),
      .retry_inc  (retry_inc),
      .cap_deriv  (cap_deriv),
      .cap_ver    (cap_ver),
      .done       (done),
      .error      (error)
   );

   sdbg_retry #(.MAX_RETRY(MAX_RETRY)) u_retry (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (retry_clr),
      .inc       (retry_inc),
      .exhausted (exhausted),
      .count     (retry_count)
   );

   sdbg_req_map #(.ADDR_W(ADDR_W), .RANGE_SEL(RANGE_SEL)) u_map (
      .phase     (phase),
      .step      (step),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_dummy (req_dummy),
      .req_addr  (req_addr),
      .req_wdata (req_wdata)
   );

   sdbg_capture u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_deriv (cap_deriv),
      .cap_ver   (cap_ver),
      .rdata     (eng_rdata),
      .id_deriv  (id_deriv),
      .id_ver    (id_ver)
   );

   p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> !req_valid);

   p_fields_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (req_addr == '0 && req_wdata == '0 && !req_write && !req_dummy));

   p_no_req_when_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !req_valid);

   p_bytes_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> ($stable(id_deriv) && $stable(id_ver)));

   p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && start) |=> (!done && !error));

   p_retry_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (error && !eng_abort && $past(eng_done)) |-> (retry_count == CNT_W'(MAX_RETRY)) || $past(eng_abort));

endmodule

// File: tb/sdbg_seq_tb_top.sv
module sdbg_eng_model #(
   parameter int LAT = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic        req_write,
   input  logic        req_dummy,
   input  logic [12:0] req_addr,
   input  logic [7:0]  req_wdata,
   input  int          ignore_writes,
   input  int          abort_at,
   output logic        eng_done,
   output logic        eng_abort,
   output logic [7:0]  eng_rdata,
   output int          n_req,
   output int          n_ctrl_rd,
   output int          n_dummy
);
   int         cnt, wr_seen;
   bit         busy, cur_abort;
   logic [7:0] mirror, resp;

   initial begin
      eng_done = 0; eng_abort = 0; eng_rdata = 0;
      n_req = 0; n_ctrl_rd = 0; n_dummy = 0;
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         busy = 0; cnt = 0; mirror = 0; wr_seen = 0; resp = 0; cur_abort = 0;
         n_req <= 0; n_ctrl_rd <= 0; n_dummy <= 0;
         eng_done <= 0; eng_abort <= 0; eng_rdata <= 0;
      end else begin
         eng_done <= 0; eng_abort <= 0; eng_rdata <= 0;
         if (busy) begin
            if (cnt == 0) begin
               busy = 0;
               if (cur_abort) eng_abort <= 1;
               else begin eng_done <= 1; eng_rdata <= resp; end
            end else cnt--;
         end
         if (req_valid) begin
            busy = 1; cnt = LAT - 1; resp = 8'h00;
            cur_abort = ((n_req + 1) == abort_at);
            n_req <= n_req + 1;
            if (req_dummy) n_dummy <= n_dummy + 1;
            else if (req_write) begin
               if (req_addr == 13'h0038) begin
                  if (wr_seen >= ignore_writes) mirror = req_wdata;
                  wr_seen++;
               end
            end else begin
               case (req_addr)
                  13'h0038: begin resp = mirror; n_ctrl_rd <= n_ctrl_rd + 1; end
                  13'h0805: resp = 8'hA5;
                  13'h0804: resp = 8'h3C;
                  13'h1542: resp = 8'h5A;
                  13'h1543: resp = 8'hC3;
                  default:  resp = 8'hEE;
               endcase
            end
         end
      end
   end
endmodule

module sdbg_seq_tb_top;
   logic clk = 0;
   always #10 clk = ~clk;

   logic rst_n, start;
   int   ign, abt;
   int   checks = 0, fails = 0, cyc = 0;

   logic        f_valid, f_write, f_dummy, f_done, f_abort, f_fin, f_err;
   logic [12:0] f_addr;
   logic [7:0]  f_wdata, f_rdata, f_deriv, f_ver;
   int          f_nreq, f_nrd, f_ndum;

   logic        h_valid, h_write, h_dummy, h_done, h_abort, h_fin, h_err;
   logic [12:0] h_addr;
   logic [7:0]  h_wdata, h_rdata, h_deriv, h_ver;
   int          h_nreq, h_nrd, h_ndum;

   sdbg_seq #(.ADDR_W(13), .RANGE_SEL(0), .MAX_RETRY(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start),
      .req_valid(f_valid), .req_write(f_write), .req_dummy(f_dummy),
      .req_addr(f_addr), .req_wdata(f_wdata),
      .eng_done(f_done), .eng_abort(f_abort), .eng_rdata(f_rdata),
      .id_deriv(f_deriv), .id_ver(f_ver), .done(f_fin), .error(f_err));

   sdbg_eng_model #(.LAT(3)) eng_fw_i (
      .clk(clk), .rst_n(rst_n), .req_valid(f_valid), .req_write(f_write),
      .req_dummy(f_dummy), .req_addr(f_addr), .req_wdata(f_wdata),
      .ignore_writes(ign), .abort_at(abt), .eng_done(f_done),
      .eng_abort(f_abort), .eng_rdata(f_rdata), .n_req(f_nreq),
      .n_ctrl_rd(f_nrd), .n_dummy(f_ndum));

   sdbg_seq #(.ADDR_W(13), .RANGE_SEL(3), .MAX_RETRY(8)) dut_hw_i (
      .clk(clk), .rst_n(rst_n), .start(start),
      .req_valid(h_valid), .req_write(h_write), .req_dummy(h_dummy),
      .req_addr(h_addr), .req_wdata(h_wdata),
      .eng_done(h_done), .eng_abort(h_abort), .eng_rdata(h_rdata),
      .id_deriv(h_deriv), .id_ver(h_ver), .done(h_fin), .error(h_err));

   sdbg_eng_model #(.LAT(1)) eng_hw_i (
      .clk(clk), .rst_n(rst_n), .req_valid(h_valid), .req_write(h_write),
      .req_dummy(h_dummy), .req_addr(h_addr), .req_wdata(h_wdata),
      .ignore_writes(ign), .abort_at(abt), .eng_done(h_done),
      .eng_abort(h_abort), .eng_rdata(h_rdata), .n_req(h_nreq),
      .n_ctrl_rd(h_nrd), .n_dummy(h_ndum));

   task automatic chk(input bit ok, input string req, input string what,
                      input int got, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, got, exp, $time);
      end
   endtask

   // behavioural reference of the firmware-window session
   int  ms, mstep, mret;
   bit  mvalid, mdone, merr;
   logic [7:0] mderiv, mver;

   always @(posedge clk) begin
      if (!rst_n) begin
         ms <= 0; mstep <= 0; mret <= 0; mvalid <= 0;
         mdone <= 0; merr <= 0; mderiv <= 0; mver <= 0;
      end else begin
         mvalid <= 1;
         if (ms == 0 || ms == 3) begin
            if (start) begin ms <= 1; mstep <= 0; mret <= 0; mdone <= 0; merr <= 0; end
         end else if (ms == 1) ms <= 2;
         else if (f_abort) begin ms <= 3; mdone <= 1; merr <= 1; end
         else if (f_done) begin
            ms <= 1;
            case (mstep)
               0: mstep <= 1;
               1: mstep <= 2;
               2: if (f_rdata[2:0] == 3'b100) mstep <= 3;
                  else if (mret == 8) begin ms <= 3; mdone <= 1; merr <= 1; end
                  else begin mret <= mret + 1; mstep <= 0; end
               3: begin mderiv <= f_rdata; mstep <= 4; end
               4: begin mver <= f_rdata; mstep <= 5; end
               default: begin ms <= 3; mdone <= 1; end
            endcase
         end
      end
   end

   function automatic int exp_addr(int s);
      case (s)
         1, 2, 5: return 'h38;
         3: return 'h805;
         4: return 'h804;
         default: return 0;
      endcase
   endfunction

   always @(negedge clk) begin
      if (mvalid && rst_n) begin
         bit v;
         v = (ms == 1);
         chk(f_valid == v, "R3", "req_valid", f_valid, v);
         chk(f_dummy == (v && mstep == 0), "R2", "req_dummy", f_dummy, v && mstep == 0);
         chk(f_write == (v && (mstep == 1 || mstep == 5)), "R2", "req_write", f_write, v && (mstep == 1 || mstep == 5));
         chk(int'(f_addr) == (v ? exp_addr(mstep) : 0), "R2", "req_addr", f_addr, v ? exp_addr(mstep) : 0);
         chk(int'(f_wdata) == ((v && mstep == 1) ? 4 : 0), "R2", "req_wdata", f_wdata, (v && mstep == 1) ? 4 : 0);
         chk(f_fin == mdone, "R8", "done", f_fin, mdone);
         chk(f_err == merr, "R8", "error", f_err, merr);
         chk(f_deriv == mderiv, "R6", "id_deriv", f_deriv, mderiv);
         chk(f_ver == mver, "R6", "id_ver", f_ver, mver);
      end
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         summary();
      end
   end

   task automatic pulse_start();
      @(negedge clk); #1 start = 1;
      @(negedge clk); #1 start = 0;
   endtask

   task automatic do_reset(input int i, input int a);
      @(negedge clk); #1 rst_n = 0; ign = i; abt = a;
      repeat (2) @(negedge clk);
      #1 rst_n = 1;
   endtask

   task automatic wait_done(input string req);
      int n = 0;
      while (!(f_fin && h_fin) && n < 5000) begin
         @(negedge clk); #1;
         n++;
      end
      chk(n < 5000, req, "session end reached", n, 5000);
   endtask

   initial begin
      rst_n = 0; start = 0; ign = 0; abt = 0;
      repeat (4) @(negedge clk);
      #1 rst_n = 1;
      @(negedge clk); #1;
      // R1 reset state
      chk(!f_valid && !f_write && !f_dummy && f_addr == 0 && f_wdata == 0, "R1", "fw request idle", f_valid, 0);
      chk(!f_fin && !f_err && f_deriv == 0 && f_ver == 0, "R1", "fw outputs zero", {f_fin, f_err}, 0);
      chk(!h_valid && !h_fin && !h_err && h_deriv == 0 && h_ver == 0, "R1", "hw outputs zero", {h_valid, h_fin}, 0);

      // clean session, with a start pulse during the session (R8)
      pulse_start();
      repeat (5) @(negedge clk);
      pulse_start();
      wait_done("R2");
      chk(f_deriv == 8'hA5, "R6", "fw derivative", f_deriv, 8'hA5);
      chk(f_ver == 8'h3C, "R6", "fw version", f_ver, 8'h3C);
      chk(h_deriv == 8'h5A, "R6", "hw derivative", h_deriv, 8'h5A);
      chk(h_ver == 8'hC3, "R6", "hw version", h_ver, 8'hC3);
      chk(!f_err && !h_err, "R8", "no error", {f_err, h_err}, 0);
      chk(f_nreq == 6 && h_nreq == 6, "R2", "request count", f_nreq, 6);
      chk(f_ndum == 1 && f_nrd == 1, "R2", "one dummy one readback", f_ndum, 1);
      repeat (20) @(negedge clk); #1;
      chk(f_fin && f_deriv == 8'hA5 && f_ver == 8'h3C, "R8", "bytes and done held", f_deriv, 8'hA5);
      chk(f_nreq == 6 && h_nreq == 6, "R3", "no request after end", f_nreq, 6);

      // restart from ended state
      pulse_start();
      chk(!f_fin && !h_fin, "R8", "start clears done", f_fin, 0);
      wait_done("R8");
      chk(f_nreq == 12 && !f_err && h_deriv == 8'h5A, "R8", "second session", f_nreq, 12);

      // two ignored hold writes: retried and recovered
      do_reset(2, 0);
      pulse_start();
      wait_done("R4");
      chk(f_ndum == 3 && f_nrd == 3, "R4", "retry dummies", f_ndum, 3);
      chk(h_ndum == 3 && h_nrd == 3, "R4", "hw retry dummies", h_ndum, 3);
      chk(!f_err && !h_err && f_deriv == 8'hA5 && h_ver == 8'hC3, "R4", "recovered session", f_err, 0);

      // hold never takes: retry budget runs out
      do_reset(1000, 0);
      pulse_start();
      wait_done("R5");
      chk(f_err && h_err, "R5", "error on exhaustion", f_err, 1);
      chk(f_nrd == 9 && h_nrd == 9, "R5", "readbacks", f_nrd, 9);
      chk(f_nreq == 27 && h_nreq == 27, "R5", "no release write", f_nreq, 27);

      // abort on the fourth request (derivative read)
      do_reset(0, 4);
      pulse_start();
      wait_done("R7");
      chk(f_err && h_err, "R7", "error on abort", f_err, 1);
      chk(f_deriv == 0 && h_deriv == 0, "R7", "no capture after abort", f_deriv, 0);
      repeat (10) @(negedge clk); #1;
      chk(f_nreq == 4 && h_nreq == 4, "R7", "no request after abort", f_nreq, 4);

      summary();
   end
endmodule